// File: doc/BRIEF.md
# Receive Control Word Checker

This block sits on the receive path of a 16-bit packet interface, after the lanes have been aligned. Each clock it takes one word and a flag that says whether the word is control or data. Control words are decoded into a start-of-packet mark, an end-of-packet status and an 8-bit channel number. Data words are passed through unchanged, one cycle later. The block also keeps a 4-bit interleaved parity over the stream and checks it at every payload control word.

It detects a start-of-packet that follows the previous one too closely, a non-zero pad byte on a packet of odd length, aborted packets, parity mismatches and control words with undefined encodings. Each of these raises a one-cycle error pulse. A pad fault or an abort also marks the packet as errored on its end-of-packet marker. A packet marked this way is always reported as ending on a full word, so its byte count is even. After an undefined control word, data is discarded until the next payload control word arrives.

Top module: `rx_ctrl_word_chk`

## Requirements
- R1: A data word (`is_ctrl_i`=0) that is neither training data nor discarded appears on `dat_o` unchanged, with `dat_vld_o`=1, exactly one clock after it is presented. Control words never assert `dat_vld_o`.
- R2: A start-of-packet that comes fewer than 8 cycles after the previous one pulses `err_sop_gap_o` together with `sop_o`. A start-of-packet 8 or more cycles later does not. The first start-of-packet after reset never violates. Data forwarding is unaffected.
- R3: An end-of-packet with status 11 (one valid byte, in bits 15:8 of the last data word) whose last data word has a non-zero low byte pulses `err_pad_o` and asserts `pkt_err_o` with `eop_o`.
- R4: An end-of-packet with status 01 (abort) pulses `err_abort_o` and asserts `pkt_err_o` with `eop_o`.
- R5: The parity is formed as follows. Take the XOR of every non-training word since the previous payload control word, and XOR in the current control word with bits 3:0 forced to 1111. Then fold the result by XOR-ing its four nibbles. If this value differs from bits 3:0 of the payload control word, `err_dip4_o` pulses. The accumulation then restarts.
- R6: A control word with bit 15=0 that is neither idle nor training pulses `err_rsvd_o`. The data words after it are not forwarded until the next payload control word.
- R7: `eop_odd_o` is 1 only for an end-of-packet with status 11 that is not errored. Whenever `pkt_err_o` is 1, `eop_odd_o` is 0.
- R8: A control word with bit 15=1 is a payload control word. Its bits 14:13 are the end-of-packet status (00 none, 01 abort, 10 two bytes, 11 one byte), bit 12 is start-of-packet and bits 11:4 are the channel. `sop_o` and `chan_o` follow one cycle later, and `eop_o` follows for any status other than 00.
- R9: An idle control word (bits 15:4 all zero) and a training control word (bits 15:4 = 0x0FF) never produce `sop_o` or `eop_o`. Data words that follow a training control word, up to the next control word, are training data. They are neither forwarded nor counted in the parity. Idle words are counted in the parity.
- R10: While `rst_ni` is low, every output is 0, and the parity accumulator and the spacing counter return to their initial state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_i | input | 16 | Received word |
| is_ctrl_i | input | 1 | 1 = control word, 0 = data word |
| dat_o | output | 16 | Forwarded data word |
| dat_vld_o | output | 1 | `dat_o` holds a forwarded word |
| sop_o | output | 1 | Start of packet |
| chan_o | output | 8 | Channel of the latest start of packet |
| eop_o | output | 1 | End of packet |
| eop_odd_o | output | 1 | Packet ends with one valid byte |
| pkt_err_o | output | 1 | Packet ending now is errored |
| err_sop_gap_o | output | 1 | Start-of-packet spacing violation |
| err_pad_o | output | 1 | Non-zero pad byte |
| err_abort_o | output | 1 | Aborted packet received |
| err_dip4_o | output | 1 | Parity mismatch |
| err_rsvd_o | output | 1 | Undefined control word |

## Verification
The assertions hold on every cycle. They check that forwarded data equals the word of the cycle before, that data and control events never coincide, that every pad or abort flag comes with an errored end-of-packet, that an errored end is never reported as odd, and that the spacing flag fires exactly when a start-of-packet arrives inside the window. Only the bench scenarios can show the rest. These are the parity value itself across all sixteen parity codes, the exclusion of training data from the parity, the discarding and the resumption of data around an undefined control word, and the full sweep of start-of-packet distances across the window boundary.

// File: rtl/spi_rx_pkg.sv
package spi_rx_pkg;

  localparam int WORD_W = 16;
  localparam int CHAN_W = 8;
  localparam int DIP_W  = 4;

  typedef enum logic [1:0] {
    EOP_NONE  = 2'b00,
    EOP_ABORT = 2'b01,
    EOP_TWO   = 2'b10,
    EOP_ONE   = 2'b11
  } eop_stat_e;

  typedef enum logic [2:0] {
    CW_DATA,
    CW_PAYLOAD,
    CW_IDLE,
    CW_TRAIN,
    CW_RSVD
  } cw_kind_e;

  typedef struct packed {
    cw_kind_e          kind;
    eop_stat_e         eop;
    logic              sop;
    logic [CHAN_W-1:0] chan;
    logic [DIP_W-1:0]  dip;
  } cw_info_t;

  function automatic logic [DIP_W-1:0] fold_nibbles(logic [WORD_W-1:0] x);
    logic [DIP_W-1:0] r;
    r = '0;
    for (int i = 0; i < WORD_W / DIP_W; i++) r ^= x[i*DIP_W +: DIP_W];
    return r;
  endfunction

endpackage

// File: rtl/cw_decode.sv
module cw_decode
  import spi_rx_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic              is_ctrl_i,
  input  logic              train_i,
  output cw_info_t          info_o
);

  localparam logic [11:0] IDLE_HI  = 12'h000;
  localparam logic [11:0] TRAIN_HI = 12'h0FF;

  always_comb begin
    info_o.eop  = eop_stat_e'(word_i[14:13]);
    info_o.sop  = word_i[12];
    info_o.chan = word_i[11:4];
    info_o.dip  = word_i[3:0];
    if (!is_ctrl_i) begin
      info_o.kind = train_i ? CW_TRAIN : CW_DATA;
    end else if (word_i[15]) begin
      info_o.kind = CW_PAYLOAD;
    end else if (word_i[15:4] == IDLE_HI) begin
      info_o.kind = CW_IDLE;
    end else if (word_i[15:4] == TRAIN_HI) begin
      info_o.kind = CW_TRAIN;
    end else begin
      info_o.kind = CW_RSVD;
    end
  end

endmodule

// File: rtl/dip4_acc.sv
module dip4_acc
  import spi_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] word_i,
  input  cw_kind_e          kind_i,
  output logic              mismatch_o
);

  logic [WORD_W-1:0] acc_q, acc_d;
  logic [DIP_W-1:0]  calc;

  // parity field of the checking word counts as all ones
  assign calc = fold_nibbles(acc_q ^ {word_i[WORD_W-1:DIP_W], {DIP_W{1'b1}}});
  assign mismatch_o = (kind_i == CW_PAYLOAD) && (calc != word_i[DIP_W-1:0]);

  always_comb begin
    unique case (kind_i)
      CW_PAYLOAD: acc_d = '0;
      CW_TRAIN:   acc_d = acc_q;
      default:    acc_d = acc_q ^ word_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

endmodule

// File: rtl/sop_gap_mon.sv
module sop_gap_mon #(
  parameter int MIN_GAP = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sop_i,
  output logic viol_o
);

  localparam int CNT_W = $clog2(MIN_GAP + 1);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(MIN_GAP);

  logic [CNT_W-1:0] cnt_q;

  assign viol_o = sop_i && (cnt_q < SAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= SAT;
    else if (sop_i)      cnt_q <= CNT_W'(1);
    else if (cnt_q != SAT) cnt_q <= cnt_q + CNT_W'(1);
  end

endmodule

// File: rtl/rx_ctrl_word_chk.sv
module rx_ctrl_word_chk
  import spi_rx_pkg::*;
#(
  parameter int MIN_SOP_GAP = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] word_i,
  input  logic        is_ctrl_i,
  output logic [15:0] dat_o,
  output logic        dat_vld_o,
  output logic        sop_o,
  output logic [7:0]  chan_o,
  output logic        eop_o,
  output logic        eop_odd_o,
  output logic        pkt_err_o,
  output logic        err_sop_gap_o,
  output logic        err_pad_o,
  output logic        err_abort_o,
  output logic        err_dip4_o,
  output logic        err_rsvd_o
);

  localparam int PAD_W = WORD_W / 2;

  cw_info_t    info;
  logic        train_q, drop_q;
  logic [PAD_W-1:0] last_pad_q;
  logic        is_pay, sop_ev, eop_ev, fwd, pad_bad, abort_ev, gap_viol, dip_bad;

  cw_decode u_dec (
    .word_i    (word_i),
    .is_ctrl_i (is_ctrl_i),
    .train_i   (train_q),
    .info_o    (info)
  );

  dip4_acc u_dip (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .word_i     (word_i),
    .kind_i     (info.kind),
    .mismatch_o (dip_bad)
  );

  assign is_pay   = info.kind == CW_PAYLOAD;
  assign sop_ev   = is_pay && info.sop;
  assign eop_ev   = is_pay && (info.eop != EOP_NONE);
  assign fwd      = (info.kind == CW_DATA) && !drop_q;
  assign pad_bad  = eop_ev && (info.eop == EOP_ONE) && (last_pad_q != '0);
  assign abort_ev = eop_ev && (info.eop == EOP_ABORT);

  sop_gap_mon #(.MIN_GAP(MIN_SOP_GAP)) u_gap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sop_i  (sop_ev),
    .viol_o (gap_viol)
  );

  // stream context
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      train_q    <= 1'b0;
      drop_q     <= 1'b0;
      last_pad_q <= '0;
    end else begin
      if (is_ctrl_i) train_q <= (info.kind == CW_TRAIN);
      if (info.kind == CW_RSVD) drop_q <= 1'b1;
      else if (is_pay)          drop_q <= 1'b0;
      if (info.kind == CW_DATA) last_pad_q <= word_i[PAD_W-1:0];
    end
  end

  // registered outputs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dat_o         <= '0;
      dat_vld_o     <= 1'b0;
      sop_o         <= 1'b0;
      chan_o        <= '0;
      eop_o         <= 1'b0;
      eop_odd_o     <= 1'b0;
      pkt_err_o     <= 1'b0;
      err_sop_gap_o <= 1'b0;
      err_pad_o     <= 1'b0;
      err_abort_o   <= 1'b0;
      err_dip4_o    <= 1'b0;
      err_rsvd_o    <= 1'b0;
    end else begin
      dat_vld_o     <= fwd;
      if (fwd) dat_o <= word_i;
      sop_o         <= sop_ev;
      if (sop_ev) chan_o <= info.chan;
      eop_o         <= eop_ev;
      pkt_err_o     <= pad_bad || abort_ev;
      // errored packets are reported as ending on a full word
      eop_odd_o     <= eop_ev && (info.eop == EOP_ONE) && !pad_bad;
      err_sop_gap_o <= gap_viol;
      err_pad_o     <= pad_bad;
      err_abort_o   <= abort_ev;
      err_dip4_o    <= dip_bad;
      err_rsvd_o    <= info.kind == CW_RSVD;
    end
  end

endmodule

// File: rtl/rx_ctrl_word_chk_sva.sv
module rx_ctrl_word_chk_sva #(
  parameter int MIN_SOP_GAP = 8
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] word_i,
  input logic        dat_vld_o,
  input logic [15:0] dat_o,
  input logic        sop_o,
  input logic        eop_o,
  input logic        eop_odd_o,
  input logic        pkt_err_o,
  input logic        err_sop_gap_o,
  input logic        err_pad_o,
  input logic        err_abort_o,
  input logic        err_dip4_o,
  input logic        err_rsvd_o
);

  localparam int CW = $clog2(MIN_SOP_GAP + 1);

  logic [CW-1:0] since_sop;
  logic          seen_clk;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_sop <= CW'(MIN_SOP_GAP);
      seen_clk  <= 1'b0;
    end else begin
      seen_clk <= 1'b1;
      if (sop_o) since_sop <= CW'(1);
      else if (since_sop != CW'(MIN_SOP_GAP)) since_sop <= since_sop + CW'(1);
    end
  end

  p_pass_through_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_clk && dat_vld_o |-> dat_o == $past(word_i));

  p_data_ctrl_excl_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dat_vld_o, sop_o || eop_o || err_dip4_o || err_rsvd_o}));

  p_gap_window_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_sop_gap_o == (sop_o && since_sop < CW'(MIN_SOP_GAP)));

  p_pad_marks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_pad_o |-> eop_o && pkt_err_o);

  p_abort_marks_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_abort_o |-> eop_o && pkt_err_o);

  p_even_on_err_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_err_o |-> !eop_odd_o);

  p_end_status_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_err_o || eop_odd_o) |-> eop_o);

  p_err_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_err_o |-> err_pad_o || err_abort_o);

endmodule

bind rx_ctrl_word_chk rx_ctrl_word_chk_sva #(.MIN_SOP_GAP(MIN_SOP_GAP)) i_sva (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .word_i        (word_i),
  .dat_vld_o     (dat_vld_o),
  .dat_o         (dat_o),
  .sop_o         (sop_o),
  .eop_o         (eop_o),
  .eop_odd_o     (eop_odd_o),
  .pkt_err_o     (pkt_err_o),
  .err_sop_gap_o (err_sop_gap_o),
  .err_pad_o     (err_pad_o),
  .err_abort_o   (err_abort_o),
  .err_dip4_o    (err_dip4_o),
  .err_rsvd_o    (err_rsvd_o)
);

// File: tb/test_rx_ctrl_word_chk.sv
module test_rx_ctrl_word_chk;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] word = '0;
  logic        is_ctrl = 1'b0;
  logic [15:0] dat;
  logic        dat_vld, sop, eop, eop_odd, pkt_err;
  logic        e_gap, e_pad, e_abort, e_dip, e_rsvd;
  logic [7:0]  chan;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [15:0] tb_acc = '0;
  bit          tb_train = 1'b0;

  always #4 clk = ~clk;

  rx_ctrl_word_chk i_rx_ctrl_word_chk (
    .clk_i(clk), .rst_ni(rst_n), .word_i(word), .is_ctrl_i(is_ctrl),
    .dat_o(dat), .dat_vld_o(dat_vld), .sop_o(sop), .chan_o(chan),
    .eop_o(eop), .eop_odd_o(eop_odd), .pkt_err_o(pkt_err),
    .err_sop_gap_o(e_gap), .err_pad_o(e_pad), .err_abort_o(e_abort),
    .err_dip4_o(e_dip), .err_rsvd_o(e_rsvd)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] fold(logic [15:0] x);
    return x[15:12] ^ x[11:8] ^ x[7:4] ^ x[3:0];
  endfunction

  // drive one word, wait for its registered result
  task automatic send(input logic [15:0] w, input bit c);
    @(negedge clk);
    word = w;
    is_ctrl = c;
    if (c && w[15])                      tb_acc = '0;
    else if (!(c && w[15:4] == 12'h0FF) && !(!c && tb_train)) tb_acc ^= w;
    if (c) tb_train = (w[15:4] == 12'h0FF);
    @(posedge clk);
    #2;
  endtask

  function automatic logic [15:0] pay(input logic [1:0] st, input bit s, input logic [7:0] ch, input bit good);
    logic [15:0] w;
    w = {1'b1, st, s, ch, 4'h0};
    w[3:0] = fold(tb_acc ^ {w[15:4], 4'hF}) ^ (good ? 4'h0 : 4'h1);
    return w;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R10: reset state
    chk({dat_vld, sop, eop, eop_odd, pkt_err, e_gap, e_pad, e_abort, e_dip, e_rsvd} == '0 && chan == 0 && dat == 0,
        "R10 reset outputs", {dat_vld, sop, eop, pkt_err, e_dip}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R8: payload control decode; first sop after reset has no gap error (R2)
    send(pay(2'b00, 1'b1, 8'h5A, 1'b1), 1'b1);
    chk(sop && chan == 8'h5A && !eop && !dat_vld, "R8 sop/chan decode", {sop, chan}, {1'b1, 8'h5A});
    chk(!e_gap && !e_dip, "R2 first sop no violation", {e_gap, e_dip}, 0);

    // R1: data pass-through, several patterns
    for (int i = 0; i < 6; i++) begin
      logic [15:0] v;
      v = 16'h1357 * 16'(i + 1) ^ 16'hA5C3;
      send(v, 1'b0);
      chk(dat_vld && dat == v && !sop && !eop, "R1 data forwarded", dat, v);
    end
    send(pay(2'b10, 1'b0, 8'h00, 1'b1), 1'b1);
    chk(eop && !pkt_err && !eop_odd && !dat_vld && !e_dip, "R8 eop two bytes", {eop, pkt_err, eop_odd}, 3'b100);

    // R5: every parity code after varying data runs
    for (int d = 0; d < 16; d++) begin
      logic [15:0] w;
      logic [3:0]  good;
      for (int k = 0; k < d % 5; k++) send(16'h0F1E + 16'(d * 37 + k * 911), 1'b0);
      w = pay(2'b00, 1'b0, 8'(d * 13), 1'b1);
      good = w[3:0];
      w[3:0] = 4'(d);
      send(w, 1'b1);
      tb_acc = '0;
      chk(e_dip == (4'(d) != good), "R5 parity check", e_dip, (4'(d) != good));
    end

    // R2: start-of-packet spacing sweep across the window
    for (int g = 1; g <= 11; g++) begin
      for (int k = 0; k < 9; k++) send(16'h0000, 1'b1);
      send(pay(2'b00, 1'b1, 8'h11, 1'b1), 1'b1);
      for (int k = 0; k < g - 1; k++) send(16'h00FF + 16'(k), 1'b0);
      send(pay(2'b00, 1'b1, 8'h22, 1'b1), 1'b1);
      chk(sop && e_gap == (g < 8) && !e_dip, "R2 sop spacing", {sop, e_gap}, {1'b1, (g < 8)});
    end

    // R3/R7: pad byte on one-valid-byte end
    for (int p = 0; p < 5; p++) begin
      logic [7:0] pb;
      pb = (p == 0) ? 8'h00 : (p == 1) ? 8'h01 : (p == 2) ? 8'h80 : (p == 3) ? 8'hFF : 8'h3C;
      for (int k = 0; k < 9; k++) send(16'h0000, 1'b1);
      send(pay(2'b00, 1'b1, 8'h33, 1'b1), 1'b1);
      send({8'hC4, pb}, 1'b0);
      send(pay(2'b11, 1'b0, 8'h00, 1'b1), 1'b1);
      chk(eop && e_pad == (pb != 0) && pkt_err == (pb != 0), "R3 pad byte check", {e_pad, pkt_err}, {(pb != 0), (pb != 0)});
      chk(eop_odd == (pb == 0), "R7 even size when errored", eop_odd, (pb == 0));
    end

    // R4: abort
    send(16'h7777, 1'b0);
    send(pay(2'b01, 1'b0, 8'h00, 1'b1), 1'b1);
    chk(eop && pkt_err && e_abort && !eop_odd && !e_pad, "R4 abort end", {eop, pkt_err, e_abort, eop_odd}, 4'b1110);

    // R6: undefined control word drops data until next payload control
    send(16'h1000, 1'b1);
    chk(e_rsvd && !sop && !eop, "R6 undefined control flagged", {e_rsvd, sop}, 2'b10);
    send(16'hBEEF, 1'b0);
    chk(!dat_vld, "R6 data dropped", dat_vld, 0);
    send(16'h1234, 1'b0);
    chk(!dat_vld, "R6 data dropped", dat_vld, 0);
    send(pay(2'b00, 1'b0, 8'h00, 1'b1), 1'b1);
    chk(!e_dip && !e_rsvd, "R6 parity includes dropped data (R5)", e_dip, 0);
    send(16'hCAFE, 1'b0);
    chk(dat_vld && dat == 16'hCAFE, "R6 forwarding resumes", dat, 16'hCAFE);

    // R9: idle and training words
    send(16'h000A, 1'b1);
    chk(!sop && !eop && !e_rsvd && !dat_vld, "R9 idle is non-payload", {sop, eop, e_rsvd}, 0);
    send(16'h0FFF, 1'b1);
    chk(!sop && !eop && !e_rsvd, "R9 training control non-payload", {sop, eop, e_rsvd}, 0);
    send(16'hF000, 1'b0);
    chk(!dat_vld, "R9 training data not forwarded", dat_vld, 0);
    send(16'hF000, 1'b0);
    send(pay(2'b00, 1'b1, 8'h44, 1'b1), 1'b1);
    chk(!e_dip && sop, "R9 training excluded, idle included in parity", e_dip, 0);
    send(16'hF000, 1'b0);
    chk(dat_vld && dat == 16'hF000, "R9 ordinary data after training", dat, 16'hF000);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule